// File: doc/BRIEF.md
# Clock-Down Handshake Controller

This block sits beside a serial audio receiver core and decides when its clock may safely be stopped. Software sees one 8-bit control register. It holds a power-on bit that software writes, and a read-only status bit that reports that the clock may now be gated. Clearing the power-on bit asks for a shutdown. The controller blocks new downstream transactions at once. It then waits for two things: the receiver's input stream must reach its next subframe boundary, and any request still outstanding toward the downstream sink must be acknowledged. Only after both does it raise the status bit.

An external gate cell stops the clock when the status bit is high and the power-on bit is low. Software may restore the clock at any time and then set the power-on bit. That clears the status bit on the next cycle and lets the receiver run again. Software is expected to apply the receiver's software reset right after it re-enables the clock. The controller also drives a halt signal that tells the receiver to stop checking its input once the boundary has been reached.

Top module: `clkdown_hs`

## Requirements
- R1: After reset the register reads 8'h02 (power-on bit 0, status bit 1), the status output is 1, the halt output is 1 and the transaction enable is 0.
- R2: The read data places the power-on bit at bit 0 and the status bit at bit 1, and bits 7:2 read as 0. Write data in bits 7:1 has no effect on the read value or on any output.
- R3: A write with bit 0 = 1 in any state gives, from the next cycle on, status 0, power-on 1, transaction enable 1 and halt 0.
- R4: A write with bit 0 = 0 while running gives, from the next cycle on, transaction enable 0, with the status still 0 while the controller drains.
- R5: While draining, the status rises in the cycle after the first cycle in which a boundary has been seen (a strobe in that cycle or one latched earlier) and no request is outstanding. An acknowledge arriving in that same cycle counts as clearing the outstanding request.
- R6: While a request is outstanding the status stays 0, even after a boundary strobe. The boundary is remembered, so that a later acknowledge alone completes the drain.
- R7: The halt output rises in the cycle after the first boundary strobe seen while draining. It stays high until a write sets the power-on bit.
- R8: A write with bit 0 = 1 during draining returns the block to running without the status bit ever rising.
- R9: Boundary strobes that arrive while running are not counted. After a shutdown request, a new strobe is required.
- R10: A request issue sets the outstanding flag and an acknowledge clears it. An issue and an acknowledge in the same cycle leave the flag set, because the new request is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| sf_bound_i | input | 1 | Receiver strobe marking the start of the next subframe |
| req_issue_i | input | 1 | A request toward the downstream sink is issued this cycle |
| sink_ack_i | input | 1 | Downstream sink acknowledges the outstanding request |
| rdy_o | output | 1 | Ready for clock down status |
| halt_o | output | 1 | Tells the receiver to stop checking its input |
| txn_en_o | output | 1 | New transactions allowed |

## Verification
Directed sequences separate the ordering cases of the drain. In one the boundary arrives before the acknowledge, in one after it, and in one together with it. Further sequences cover a boundary that arrives while still running, and a wake-up that lands in the middle of a drain. Each of these cases shows whether the boundary is latched, whether a same-cycle acknowledge is honoured, and whether an early strobe is wrongly counted. A seeded random stream mixes writes, strobes, issues and acknowledges at uneven rates, and every cycle is compared against a cycle model kept in the bench. This exposes wrong priorities between a wake-up and drain completion, and any mistake in the outstanding flag when an issue and an acknowledge coincide.

// File: rtl/clkdown_pkg.sv
package clkdown_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_READY = 2'd2
  } cd_state_e;

  localparam int unsigned PWR_BIT = 0;
  localparam int unsigned RDY_BIT = 1;
endpackage

// File: rtl/clkdown_reg.sv
module clkdown_reg
  import clkdown_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rdy_i,
  output logic             pwr_on_o,
  output logic             wake_o,
  output logic             sleep_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic pwr_q;
  logic unused_wr;

  // only the power-on bit is writable
  assign unused_wr = ^wr_data_i;
  assign wake_o    = wr_en_i &  wr_data_i[PWR_BIT];
  assign sleep_o   = wr_en_i & ~wr_data_i[PWR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pwr_q <= 1'b0;
    else if (wr_en_i) pwr_q <= wr_data_i[PWR_BIT];
  end

  assign pwr_on_o = pwr_q;

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[PWR_BIT] = pwr_q;
    rd_data_o[RDY_BIT] = rdy_i;
  end

  AST_WR_TAKES_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (pwr_on_o == $past(wr_data_i[PWR_BIT]))); // R3
endmodule

// File: rtl/clkdown_pend.sv
module clkdown_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic ack_i,
  output logic pend_q_o,
  output logic pend_d_o
);
  logic pend_q;

  // a fresh issue outlives a same-cycle ack
  assign pend_d_o = issue_i | (pend_q & ~ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d_o;
  end

  assign pend_q_o = pend_q;

  AST_ISSUE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> pend_q_o); // R10
endmodule

// File: rtl/clkdown_fsm.sv
module clkdown_fsm
  import clkdown_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic sleep_i,
  input  logic sf_bound_i,
  input  logic pend_d_i,
  output logic rdy_o,
  output logic halt_o
);
  cd_state_e st_q, st_d;
  logic      bnd_q, bnd_d;
  logic      bnd_any;

  assign bnd_any = bnd_q | sf_bound_i;

  always_comb begin
    st_d  = st_q;
    bnd_d = bnd_q;
    unique case (st_q)
      ST_RUN: begin
        if (sleep_i) begin
          st_d  = ST_DRAIN;
          bnd_d = 1'b0;
        end
      end
      ST_DRAIN: begin
        if (wake_i)                    st_d = ST_RUN;
        else if (bnd_any && !pend_d_i) st_d = ST_READY;
        else                           bnd_d = bnd_any;
      end
      ST_READY: begin
        if (wake_i) st_d = ST_RUN;
      end
      default: st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_READY;
      bnd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bnd_q <= bnd_d;
    end
  end

  assign rdy_o  = (st_q == ST_READY);
  assign halt_o = rdy_o | ((st_q == ST_DRAIN) & bnd_q);

  AST_RDY_NEEDS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> ($past(sf_bound_i) || $past(bnd_q))); // R5
  AST_DRAIN_WAKE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN && wake_i) |=> (st_q == ST_RUN && !rdy_o)); // R8
endmodule

// File: rtl/clkdown_hs.sv
module clkdown_hs
  import clkdown_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             sf_bound_i,
  input  logic             req_issue_i,
  input  logic             sink_ack_i,
  output logic             rdy_o,
  output logic             halt_o,
  output logic             txn_en_o
);
  logic pwr_on, wake, sleep, pend_q, pend_d;

  clkdown_reg #(.REG_W(REG_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .rdy_i     (rdy_o),
    .pwr_on_o  (pwr_on),
    .wake_o    (wake),
    .sleep_o   (sleep),
    .rd_data_o
  );

  clkdown_pend u_pend (
    .clk_i, .rst_ni,
    .issue_i  (req_issue_i),
    .ack_i    (sink_ack_i),
    .pend_q_o (pend_q),
    .pend_d_o (pend_d)
  );

  clkdown_fsm u_fsm (
    .clk_i, .rst_ni,
    .wake_i     (wake),
    .sleep_i    (sleep),
    .sf_bound_i,
    .pend_d_i   (pend_d),
    .rdy_o,
    .halt_o
  );

  assign txn_en_o = pwr_on;

  AST_RDY_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> !pend_q); // R6
  AST_WAKE_CLR_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[PWR_BIT]) |=> (!rdy_o && txn_en_o && !halt_o)); // R3
  AST_RDY_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> !txn_en_o); // R4
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !(wr_en_i && wr_data_i[PWR_BIT])) |=> halt_o); // R7
endmodule

// File: tb/clkdown_hs_tb.sv
`timescale 1ns/1ps
module clkdown_hs_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       sf_bound_i = 1'b0, req_issue_i = 1'b0, sink_ack_i = 1'b0;
  logic       rdy_o, halt_o, txn_en_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model: 0 run, 1 drain, 2 ready
  int   m_st = 2;
  bit   m_pwr = 0, m_bnd = 0, m_pend = 0;

  always #2 clk_i = ~clk_i;

  clkdown_hs u_dut (.*);

  function automatic logic [10:0] expv();
    logic r;
    r = (m_st == 2);
    return {6'b0, r, m_pwr, r | (m_st == 1 && m_bnd), m_pwr, r};
  endfunction

  task automatic model_step();
    bit pn, wk, sl;
    pn = req_issue_i | (m_pend & ~sink_ack_i);
    wk = wr_en_i & wr_data_i[0];
    sl = wr_en_i & ~wr_data_i[0];
    case (m_st)
      0: if (sl) begin m_st = 1; m_bnd = 0; end
      1: if (wk) m_st = 0;
         else if ((m_bnd | sf_bound_i) && !pn) m_st = 2;
         else m_bnd = m_bnd | sf_bound_i;
      default: if (wk) m_st = 0;
    endcase
    if (wr_en_i) m_pwr = wr_data_i[0];
    m_pend = pn;
  endtask

  task automatic check(string tag);
    logic [10:0] got, exp;
    got = {rd_data_o, halt_o, txn_en_o, rdy_o};
    exp = expv();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h (rd,halt,txn,rdy)", tag, got, exp);
    end
  endtask

  // drive at negedge, step model at posedge, check at next negedge
  task automatic cyc(bit w, logic [7:0] d, bit sf, bit iss, bit ack, string tag);
    wr_en_i = w; wr_data_i = d; sf_bound_i = sf; req_issue_i = iss; sink_ack_i = ack;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    wr_en_i = 0; sf_bound_i = 0; req_issue_i = 0; sink_ack_i = 0;
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");
    cyc(1, 8'hFE, 0, 0, 0, "R2 reserved write ignored");
    cyc(1, 8'hFF, 0, 0, 0, "R3 wake");
    cyc(0, 8'h00, 0, 1, 0, "R10 issue");
    cyc(1, 8'h00, 0, 0, 0, "R4 sleep with pending");
    cyc(0, 8'h00, 1, 0, 0, "R6 bound while pending");
    cyc(0, 8'h00, 0, 0, 0, "R7 halt held");
    cyc(0, 8'h00, 0, 0, 1, "R5 ack completes drain");
    cyc(0, 8'h00, 0, 0, 0, "R5 ready held");
    cyc(1, 8'h01, 0, 0, 0, "R3 wake from ready");
    cyc(0, 8'h00, 1, 0, 0, "R9 bound in run");
    cyc(1, 8'h00, 0, 0, 0, "R9 sleep");
    cyc(0, 8'h00, 0, 0, 0, "R9 no stale bound");
    cyc(1, 8'h01, 0, 0, 0, "R8 wake during drain");
    cyc(0, 8'h00, 0, 1, 0, "R10 issue");
    cyc(1, 8'h00, 0, 1, 1, "R10 issue with ack keeps pending");
    cyc(0, 8'h00, 1, 0, 1, "R5 ack with bound same cycle");
    cyc(1, 8'h81, 0, 0, 0, "R2 wake with reserved bits");
    cyc(1, 8'h00, 0, 0, 0, "R4 sleep idle");
    cyc(0, 8'h00, 1, 0, 0, "R5 bound no pending");
    begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      for (int i = 0; i < 3000; i++) begin
        bit w, sf, iss, ack;
        logic [7:0] d;
        w   = ($urandom % 8) == 0;
        d   = 8'($urandom);
        sf  = ($urandom % 5) == 0;
        iss = ($urandom % 6) == 0;
        ack = ($urandom % 4) == 0;
        cyc(w, d, sf, iss, ack, "R5 random");
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule